// File: doc/BRIEF.md
# Interleaved Audio/Video Byte Output

This block places two byte streams, audio and video, on one shared byte bus that feeds a combined audio/video decoder. Each stream arrives through a ready/valid read port from its own buffer. The decoder side gives an audio request and a video request. A board that does not use the video request ties it high. A select line travels with every byte and tells the decoder which stream the byte belongs to.

An output clock enable sets the byte rate. Each byte period takes two enabled cycles. In the first enabled cycle the block picks a stream, reads one byte from that stream, and puts the byte and its select value on the bus. In the second enabled cycle it raises the output strobe, and the strobe falls again at the next enabled cycle. A programmable ratio sets the order of slots: N video slots, then one audio slot, over and over. If the stream that owns a slot has no data, or its request is low, the other stream may use that slot. The slot is skipped and the bus does not stall. When combined mode is off, only video is sent.

Top module: `av_byte_interleaver`

## Requirements
- R1: While reset is held and right after it, outStrobe, outSel and outData are 0, and neither audReady nor vidReady is asserted.
- R2: The byte read in an arbitration cycle (an enabled cycle in even position since reset) is on outData, with outSel = 1 for audio or 0 for video, after that clock edge while outStrobe is 0. outStrobe is 1 after the next enabled edge and 0 after the enabled edge after that. outData and outSel stay unchanged while outStrobe is 1.
- R3: audReady and vidReady are asserted only in arbitration cycles with byteEn high, and never both in the same cycle. In the strobe cycles (odd position) both stay 0.
- R4: With combined mode on and both streams available, the slots repeat as ratio video slots followed by one audio slot.
- R5: A ratio value of 0 acts as 1, so video and audio slots alternate.
- R6: If the stream that owns a slot is unavailable, the other stream is sent in that slot if it is available. The slot sequence moves on by one slot in either case.
- R7: Audio is available only when audReq and audValid are both 1. Video is available only when vidReq and vidValid are both 1.
- R8: With combinedEn at 0, audReady stays 0 and every slot is a video slot. The slot sequence is held at its start, so after combinedEn goes back to 1 the pattern begins with ratio video slots.
- R9: If neither stream is available in an arbitration cycle, nothing is read, outData and outSel keep their values, and outStrobe stays 0 for that byte period. The slot still counts.
- R10: In a cycle where byteEn is 0, outData, outSel and outStrobe do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| byteEn | input | 1 | Output clock enable that sets the byte rate |
| combinedEn | input | 1 | 1: audio and video share the bus; 0: video only |
| ratio | input | 8 | Number of video slots per audio slot (0 acts as 1) |
| audReq | input | 1 | Audio request from the decoder |
| vidReq | input | 1 | Video request from the decoder (tie high if unused) |
| audData | input | 8 | Audio buffer read data |
| audValid | input | 1 | Audio buffer has a byte |
| audReady | output | 1 | Audio byte taken this cycle |
| vidData | input | 8 | Video buffer read data |
| vidValid | input | 1 | Video buffer has a byte |
| vidReady | output | 1 | Video byte taken this cycle |
| outData | output | 8 | Shared output byte |
| outSel | output | 1 | 1: byte is audio; 0: byte is video |
| outStrobe | output | 1 | Output byte strobe |

## Verification
The hardest case to reach is the audio slot that falls at the end of a long run of video slots, when the ratio is near 255. At that point the audio stream may be missing, and the slot must go to video while the sequence still moves on. The stimulus runs a directed stretch of more than 256 byte periods at ratio 255, once with both streams available and once with audio withheld at the slot where audio is due. It then mixes random availability and random gaps in the enable, and changes the ratio only while combined mode is off. Through all of this, a bench slot counter predicts which stream owns each slot.

// File: rtl/av_il_pkg.sv
package av_il_pkg;
  typedef struct packed {
    logic takeAud;
    logic takeVid;
    logic raise;
    logic drop;
  } ilStrobes_t;
endpackage

// File: rtl/av_il_ctrl.sv
module av_il_ctrl
  import av_il_pkg::*;
#(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               byteEn,
  input  logic               combinedEn,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               audReq,
  input  logic               audValid,
  input  logic               vidReq,
  input  logic               vidValid,
  output ilStrobes_t         strb
);
  logic               phaseB;
  logic               loaded;
  logic [RATIO_W-1:0] slotCnt;
  logic [RATIO_W-1:0] ratioEff;
  logic               audSlot, audOk, vidOk, grantAud, grantVid, arbTick;

  assign ratioEff = (ratio == '0) ? RATIO_W'(1) : ratio;
  assign audSlot  = combinedEn && (slotCnt >= ratioEff);
  assign audOk    = combinedEn && audReq && audValid;
  assign vidOk    = vidReq && vidValid;
  assign grantAud = audOk && (audSlot || !vidOk);
  assign grantVid = vidOk && !grantAud;
  assign arbTick  = byteEn && !phaseB;

  always_comb begin
    strb.takeAud = arbTick && grantAud;
    strb.takeVid = arbTick && grantVid;
    strb.drop    = arbTick;
    strb.raise   = byteEn && phaseB && loaded;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseB  <= 1'b0;
      loaded  <= 1'b0;
      slotCnt <= '0;
    end else begin
      if (byteEn) phaseB <= !phaseB;
      if (arbTick) loaded <= grantAud || grantVid;
      if (!combinedEn) slotCnt <= '0;
      else if (arbTick) slotCnt <= audSlot ? '0 : slotCnt + 1'b1;
    end
  end
endmodule

// File: rtl/av_il_datapath.sv
module av_il_datapath
  import av_il_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ilStrobes_t        strb,
  input  logic [DATA_W-1:0] audData,
  input  logic [DATA_W-1:0] vidData,
  output logic [DATA_W-1:0] outData,
  output logic              outSel,
  output logic              outStrobe
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData   <= '0;
      outSel    <= 1'b0;
      outStrobe <= 1'b0;
    end else begin
      if (strb.takeAud) begin
        outData <= audData;
        outSel  <= 1'b1;
      end else if (strb.takeVid) begin
        outData <= vidData;
        outSel  <= 1'b0;
      end
      if (strb.drop) outStrobe <= 1'b0;
      else if (strb.raise) outStrobe <= 1'b1;
    end
  end
endmodule

// File: rtl/av_byte_interleaver.sv
module av_byte_interleaver
  import av_il_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               byteEn,
  input  logic               combinedEn,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               audReq,
  input  logic               vidReq,
  input  logic [DATA_W-1:0]  audData,
  input  logic               audValid,
  output logic               audReady,
  input  logic [DATA_W-1:0]  vidData,
  input  logic               vidValid,
  output logic               vidReady,
  output logic [DATA_W-1:0]  outData,
  output logic               outSel,
  output logic               outStrobe
);
  ilStrobes_t strb;

  av_il_ctrl #(.RATIO_W(RATIO_W)) uCtrl (
    .clk(clk), .rstN(rstN), .byteEn(byteEn), .combinedEn(combinedEn),
    .ratio(ratio), .audReq(audReq), .audValid(audValid),
    .vidReq(vidReq), .vidValid(vidValid), .strb(strb)
  );

  av_il_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .audData(audData),
    .vidData(vidData), .outData(outData), .outSel(outSel),
    .outStrobe(outStrobe)
  );

  assign audReady = strb.takeAud;
  assign vidReady = strb.takeVid;
endmodule

// File: rtl/av_byte_interleaver_chk.sv
module av_byte_interleaver_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              byteEn,
  input logic              combinedEn,
  input logic              audReq,
  input logic              audValid,
  input logic              vidReq,
  input logic              vidValid,
  input logic              audReady,
  input logic              vidReady,
  input logic [DATA_W-1:0] outData,
  input logic              outSel,
  input logic              outStrobe
);
  // R3
  a_r3_one_ready: assert property (@(posedge clk) disable iff (!rstN)
    !(audReady && vidReady));
  // R3
  a_r3_ready_on_enable: assert property (@(posedge clk) disable iff (!rstN)
    (audReady || vidReady) |-> byteEn);
  // R7
  a_r7_audio_gate: assert property (@(posedge clk) disable iff (!rstN)
    audReady |-> (audReq && audValid));
  // R7
  a_r7_video_gate: assert property (@(posedge clk) disable iff (!rstN)
    vidReady |-> (vidReq && vidValid));
  // R8
  a_r8_no_audio_off: assert property (@(posedge clk) disable iff (!rstN)
    !combinedEn |-> !audReady);
  // R2
  a_r2_stable_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (outStrobe && $past(outStrobe)) |-> ($stable(outData) && $stable(outSel)));
  // R2
  a_r2_audio_sel: assert property (@(posedge clk) disable iff (!rstN)
    audReady |=> (outSel && !outStrobe));
  // R2
  a_r2_video_sel: assert property (@(posedge clk) disable iff (!rstN)
    vidReady |=> (!outSel && !outStrobe));
  // R10
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !$past(byteEn) |-> ($stable(outData) && $stable(outSel) && $stable(outStrobe)));
endmodule

bind av_byte_interleaver av_byte_interleaver_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .byteEn(byteEn), .combinedEn(combinedEn),
  .audReq(audReq), .audValid(audValid), .vidReq(vidReq), .vidValid(vidValid),
  .audReady(audReady), .vidReady(vidReady), .outData(outData),
  .outSel(outSel), .outStrobe(outStrobe)
);

// File: tb/av_byte_interleaver_test.sv
`timescale 1ns/100ps
module av_byte_interleaver_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       byteEn = 1'b0;
  logic       combinedEn = 1'b0;
  logic [7:0] ratio = 8'd1;
  logic       audReq = 1'b0, vidReq = 1'b0, audValid = 1'b0, vidValid = 1'b0;
  logic [7:0] audData = 8'h00, vidData = 8'h00;
  logic       audReady, vidReady, outSel, outStrobe;
  logic [7:0] outData;

  int errors = 0;
  int checks = 0;
  int slotCnt = 0;
  logic [7:0] prevData = 8'h00;
  logic       prevSel = 1'b0;
  int unsigned seed;

  always #2 clk = ~clk;

  av_byte_interleaver uut (
    .clk(clk), .rstN(rstN), .byteEn(byteEn), .combinedEn(combinedEn),
    .ratio(ratio), .audReq(audReq), .vidReq(vidReq), .audData(audData),
    .audValid(audValid), .audReady(audReady), .vidData(vidData),
    .vidValid(vidValid), .vidReady(vidReady), .outData(outData),
    .outSel(outSel), .outStrobe(outStrobe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int effRatio(input logic [7:0] r);
    return (r == 8'd0) ? 1 : int'(r);
  endfunction

  // expected grant: 0 none, 1 video, 2 audio
  function automatic int expGrant(input bit comb, input int cnt, input logic [7:0] r,
                                  input bit aR, input bit aV, input bit vR, input bit vV);
    bit audOwner = comb && (cnt == effRatio(r));
    bit aOk = comb && aR && aV;
    bit vOk = vR && vV;
    if (audOwner) return aOk ? 2 : (vOk ? 1 : 0);
    return vOk ? 1 : (aOk ? 2 : 0);
  endfunction

  task automatic idleGap(input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = outData;
      logic s = outSel, st = outStrobe;
      @(posedge clk);
      @(negedge clk);
      check(outData == d && outSel == s && outStrobe == st, "R10 idle hold", int'(outData), int'(d));
    end
  endtask

  // one byte period: arbitration tick then strobe tick
  task automatic doByte(input bit aR, input bit aV, input bit vR, input bit vV, input int gap);
    int g;
    logic [7:0] expD;
    g = expGrant(combinedEn, slotCnt, ratio, aR, aV, vR, vV);
    audReq = aR; audValid = aV; vidReq = vR; vidValid = vV;
    audData = 8'($urandom); vidData = 8'($urandom);
    byteEn = 1'b1;
    #1;
    check(audReady == (g == 2), "R6/R7 audReady", int'(audReady), int'(g == 2));
    check(vidReady == (g == 1), "R6/R7 vidReady", int'(vidReady), int'(g == 1));
    if (!combinedEn) check(!audReady, "R8 audio blocked", int'(audReady), 0);
    expD = (g == 2) ? audData : (g == 1) ? vidData : prevData;
    if (g != 0) prevSel = (g == 2);
    prevData = expD;
    @(posedge clk);
    @(negedge clk);
    byteEn = 1'b0;
    check(outData == expD, "R2 data", int'(outData), int'(expD));
    check(outSel == prevSel, "R2 select", int'(outSel), int'(prevSel));
    check(!outStrobe, "R2 strobe low at load", int'(outStrobe), 0);
    if (combinedEn) slotCnt = (slotCnt == effRatio(ratio)) ? 0 : slotCnt + 1;
    idleGap(gap);
    audReq = 1'b1; audValid = 1'b1; vidReq = 1'b1; vidValid = 1'b1;
    byteEn = 1'b1;
    #1;
    check(!audReady && !vidReady, "R3 no ready on strobe tick", int'({audReady, vidReady}), 0);
    @(posedge clk);
    @(negedge clk);
    byteEn = 1'b0;
    check(outStrobe == (g != 0), "R2/R9 strobe", int'(outStrobe), int'(g != 0));
    check(outData == expD && outSel == prevSel, "R2 stable under strobe", int'(outData), int'(expD));
    idleGap(gap);
  endtask

  task automatic setMode(input bit comb, input logic [7:0] r);
    combinedEn = 1'b0;
    ratio = r;
    @(posedge clk);
    @(negedge clk);
    slotCnt = 0;
    combinedEn = comb;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    seed = $urandom(32'h5eed_a17e);
    repeat (3) @(negedge clk);
    check(outStrobe == 0 && outSel == 0 && outData == 0, "R1 reset outputs", int'(outData), 0);
    audValid = 1'b1; vidValid = 1'b1; audReq = 1'b1; vidReq = 1'b1;
    #1;
    check(!audReady && !vidReady, "R1 no ready in reset", int'({audReady, vidReady}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outStrobe == 0 && outSel == 0 && outData == 0, "R1 after reset", int'(outData), 0);

    // R4 ratio 3, all available
    setMode(1'b1, 8'd3);
    for (int i = 0; i < 16; i++) doByte(1, 1, 1, 1, i % 3);
    // R5 ratio 0 alternates
    setMode(1'b1, 8'd0);
    for (int i = 0; i < 8; i++) doByte(1, 1, 1, 1, 0);
    // R6 skip: audio missing in its slot, video missing in its slot
    setMode(1'b1, 8'd2);
    doByte(1, 1, 1, 1, 0);
    doByte(1, 1, 0, 1, 0);   // video slot, vidReq low -> audio (R7)
    doByte(1, 0, 1, 1, 0);   // audio slot, no audio -> video (R6)
    doByte(0, 1, 1, 1, 0);
    // R9 nothing available
    doByte(0, 1, 1, 0, 1);
    doByte(1, 1, 1, 1, 0);
    // R8 combined off, audio offered
    setMode(1'b0, 8'd1);
    for (int i = 0; i < 6; i++) doByte(1, 1, 1, 1, 0);
    doByte(1, 1, 0, 1, 0);
    combinedEn = 1'b1;
    for (int i = 0; i < 6; i++) doByte(1, 1, 1, 1, 0);
    // ratio 255 long runs
    setMode(1'b1, 8'd255);
    for (int i = 0; i < 260; i++) doByte(1, 1, 1, 1, 0);
    setMode(1'b1, 8'd255);
    for (int i = 0; i < 258; i++) doByte(1, (i != 255), 1, 1, 0);
    // random mix
    for (int blk = 0; blk < 8; blk++) begin
      setMode(($urandom % 4) != 0, 8'($urandom % 6));
      for (int i = 0; i < 50; i++)
        doByte(($urandom % 4) != 0, ($urandom % 4) != 0,
               ($urandom % 4) != 0, ($urandom % 3) != 0, int'($urandom % 3));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule